// File: doc/BRIEF.md
# UART Receive Byte Buffer with Fill-Level Interrupt

This block holds received UART bytes between the deserializer and the processor bus. Each byte offered on the write side is appended to a 16-entry first-in first-out store. Software takes bytes out from the read side, oldest first. An interrupt request goes high once the number of stored bytes reaches a trigger level chosen from four values. Software can therefore collect a batch of bytes per interrupt, and the trigger level sets how much slack remains before the store fills.

The write side is a valid strobe with no ready signal. The deserializer cannot be held back, so no back-pressure is applied. A byte offered while the store is full and no byte is leaving in the same cycle is dropped, and this sets a sticky overrun flag.

The read side works as a show-ahead stream. `rd_data` always presents the oldest stored byte and is valid while `empty` is low. A pulse on `rd_pop` consumes that byte at the clock edge. A pop while the store is empty is ignored.

Top module: `rx_trig_fifo`

## Requirements
- R1: The store holds up to 16 bytes. `level` reports the stored count (0 to 16). `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` is 16.
- R2: Bytes leave in the order they arrived. While `empty` is low, `rd_data` shows the oldest stored byte, and `rd_pop` removes it at the next rising edge.
- R3: `trig_sel` selects the trigger level with the encoding 00=1, 01=4, 10=8, 11=14. `irq` is a registered level: after each rising edge it equals (level before that edge >= trigger level selected before that edge).
- R4: A write while full without a pop in the same cycle is discarded. The count and the stored bytes are unchanged.
- R5: A discarded write sets `overrun` at the same edge.
- R6: `overrun` stays high until a cycle with `ovr_clr` high. If a clear and a discarded write occur in the same cycle, `overrun` stays high.
- R7: A write and a pop in the same cycle while full both take effect. `level` stays 16 and `overrun` is not set.
- R8: A pop while empty is ignored. If no write occurs in that cycle, `level` stays 0. A write in the same cycle is still stored.
- R9: While reset is active, and immediately after it, the block is empty: `level` is 0, and `irq` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte offered by the deserializer this cycle |
| wr_data | input | 8 | Offered byte |
| rd_pop | input | 1 | Consume the byte on `rd_data` |
| trig_sel | input | 2 | Trigger level select (00=1, 01=4, 10=8, 11=14) |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Oldest stored byte (valid while `empty` is low) |
| level | output | 5 | Number of stored bytes |
| empty | output | 1 | Store holds no byte |
| full | output | 1 | Store holds 16 bytes |
| irq | output | 1 | Fill level at or above the trigger level (registered) |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
The hardest situations to reach are the ones that need the store sitting exactly at full while several strobes land in one cycle. These are: a write together with a pop at full, a dropped write together with `ovr_clr`, and a trigger change on the same edge as a count change. The stimulus first fills the store to exactly 16 with directed writes. It then holds it there and applies each of these combinations in turn. A long randomized phase follows, with write and pop probabilities biased toward full and toward empty. This phase revisits both boundaries many times under every trigger setting, and the behavioural queue model is compared on every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_HALF    = 2'b10,
    TRIG_NEAR    = 2'b11
  } trig_sel_e;

  // Trigger thresholds scaled from the depth: 1, depth/4, depth/2, depth-2
  function automatic int trig_level(input logic [1:0] sel, input int depth);
    case (trig_sel_e'(sel))
      TRIG_ONE:     return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_pop,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          is_full, is_empty, do_rd, do_wr;

  assign is_full  = (count == CW'(DEPTH));
  assign is_empty = (count == '0);
  assign do_rd    = rd_pop && !is_empty;
  assign do_wr    = wr_valid && (!is_full || do_rd);
  assign drop     = wr_valid && !do_wr;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

endmodule

// File: rtl/rxf_trig.sv
module rxf_trig #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trig_sel,
  output logic          irq
);

  logic [CW-1:0] thr;

  assign thr = CW'(rxf_pkg::trig_level(trig_sel, DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (count >= thr);
  end

endmodule

// File: rtl/rxf_ovr.sv
module rxf_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (drop) flag <= 1'b1;   // a new drop wins over a clear
    else if (clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_pop,
  input  logic [1:0]    trig_sel,
  input  logic          ovr_clr,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          irq,
  output logic          overrun
);

  logic drop;

  rxf_store #(.W(W), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .count(level), .drop(drop)
  );

  rxf_trig #(.DEPTH(DEPTH)) i_trig (
    .clk(clk), .rst_n(rst_n), .count(level), .trig_sel(trig_sel), .irq(irq)
  );

  rxf_ovr i_ovr (
    .clk(clk), .rst_n(rst_n), .drop(drop), .clr(ovr_clr), .flag(overrun)
  );

  assign empty = (level == '0);
  assign full  = (level == CW'(DEPTH));

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          rd_pop,
  input logic [1:0]    trig_sel,
  input logic          ovr_clr,
  input logic [CW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          irq,
  input logic          overrun
);

  logic [CW-1:0] thr_now;
  assign thr_now = CW'(rxf_pkg::trig_level(trig_sel, DEPTH));

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R1
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(level >= thr_now)); // R3
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_valid && !rd_pop |=> full && overrun); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun); // R6
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_valid && rd_pop && !overrun && !ovr_clr |=> full && !overrun); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_pop && !wr_valid |=> empty); // R8

endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_pop(rd_pop),
  .trig_sel(trig_sel), .ovr_clr(ovr_clr), .level(level), .empty(empty),
  .full(full), .irq(irq), .overrun(overrun)
);

// File: tb/test_rx_trig_fifo.sv
module test_rx_trig_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_pop = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       empty, full, irq, overrun;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] q[$];
  bit m_irq = 0;
  bit m_ovr = 0;
  logic [7:0] seq = 8'h10;

  always #4 clk = ~clk;

  rx_trig_fifo i_rx_trig_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_pop(rd_pop), .trig_sel(trig_sel), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .level(level), .empty(empty), .full(full),
    .irq(irq), .overrun(overrun)
  );

  function automatic int thr(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string what, input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk("level", {"R1 ", tag}, int'(level), q.size());
    chk("empty", "R1", int'(empty), int'(q.size() == 0));
    chk("full", "R1", int'(full), int'(q.size() == 16));
    chk("irq", "R3", int'(irq), int'(m_irq));
    chk("overrun", {"R5 R6 ", tag}, int'(overrun), int'(m_ovr));
    if (q.size() > 0) chk("rd_data", {"R2 ", tag}, int'(rd_data), int'(q[0]));
  endtask

  // Drive one cycle at the falling edge, advance the model, compare at the next falling edge
  task automatic step(input bit w, input bit p, input logic [1:0] s, input bit c, input string tag);
    bit can_rd, can_wr;
    wr_valid = w; rd_pop = p; trig_sel = s; ovr_clr = c;
    if (w) begin wr_data = seq; seq = seq + 8'd7; end
    can_rd = p && q.size() > 0;
    can_wr = w && (q.size() < 16 || can_rd);
    m_irq = q.size() >= thr(s);
    if (w && !can_wr) m_ovr = 1;
    else if (c) m_ovr = 0;
    if (can_rd) void'(q.pop_front());
    if (can_wr) q.push_back(wr_data);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9");
    rst_n = 1'b1;
    step(0, 0, 2'b00, 0, "R9");
    // R8: pops on empty are ignored, pop with write stores the write
    step(0, 1, 2'b00, 0, "R8");
    step(0, 1, 2'b01, 0, "R8");
    step(1, 1, 2'b00, 0, "R8");
    step(0, 1, 2'b00, 0, "R2");
    // R3: fill across every trigger setting
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 16; k++) step(1, 0, 2'(s), 0, "R3");
      for (int k = 0; k < 16; k++) step(0, 1, 2'(s), 0, "R2");
    end
    // fill to full, then overflow
    for (int k = 0; k < 16; k++) step(1, 0, 2'b11, 0, "R1");
    step(1, 0, 2'b11, 0, "R4");
    step(1, 0, 2'b10, 0, "R4");
    step(0, 0, 2'b10, 0, "R6");
    step(1, 0, 2'b10, 1, "R6");   // clear plus drop keeps flag
    step(0, 0, 2'b10, 1, "R6");   // plain clear
    step(1, 1, 2'b10, 0, "R7");
    step(1, 1, 2'b01, 0, "R7");
    for (int k = 0; k < 16; k++) step(0, 1, 2'b00, 0, "R2");
    step(0, 1, 2'b00, 0, "R8");
    // randomized phases biased toward full then toward empty
    for (int ph = 0; ph < 8; ph++) begin
      for (int k = 0; k < 300; k++) begin
        bit w, p, c;
        w = (ph % 2 == 0) ? ($urandom_range(0, 9) < 7) : ($urandom_range(0, 9) < 3);
        p = (ph % 2 == 0) ? ($urandom_range(0, 9) < 3) : ($urandom_range(0, 9) < 7);
        c = ($urandom_range(0, 19) == 0);
        step(w, p, 2'($urandom_range(0, 3)), c, "R7");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule